// File: doc/BRIEF.md
# Block RAM request/response server

This block puts a single-port, single-clock synchronous memory behind two valid/ready channels. A requester sends operations on the request channel. Each operation carries a per-lane write-enable vector, a flag that asks for a write acknowledgement, a word address and a data word. An all-zero enable vector makes the operation a read. The response channel returns each read word. It also returns an all-zero acknowledgement word for any write that asked for one.

The read path can be one or two register stages deep. Results enter a small output FIFO, which hides the memory latency from a consumer that may stall at any time. Reservation logic counts the results still in the pipeline plus the FIFO entries. A request is accepted only while that sum is below the FIFO depth, so a returning result always finds a free slot.

Write acknowledgements can either follow the read pipeline or go straight into the FIFO in the cycle the write is accepted. A clear input throws away every pending response and leaves the stored words alone.

Top module: `bram_server`

## Requirements
- R1: A read returns the word stored at its address. Responses leave in request order, and a response that is not taken keeps its valid and its data unchanged.
- R2: Each enable bit i writes only data bits [i*DATA_W/LANES +: DATA_W/LANES] of the addressed word. Lanes whose bit is clear keep their old contents.
- R3: Results in the pipeline plus FIFO entries never exceed OUT_DEPTH. Starting from empty with the consumer stalled, exactly OUT_DEPTH response-producing requests are accepted, and after that req_ready stays low.
- R4: A read accepted at clock edge t shows rsp_valid from edge t+1 when LATENCY is 1, and from edge t+2 when LATENCY is 2.
- R5: A write produces a response only when req_want_ack is set, and the response word is all zeros. With WR_BYPASS off, the acknowledgement has the same timing as a read.
- R6: With WR_BYPASS on, an acknowledged write accepted at edge t shows rsp_valid from edge t. When LATENCY is 2, such a write is held off while an older result sits in the first pipeline stage, so request order is kept.
- R7: A clear empties the output FIFO and the pipeline, so rsp_valid is low after the edge that samples it. The stored words are unchanged.
- R8: A request accepted in a clear cycle, and a result leaving the pipeline in that cycle, produce no response. req_ready is high again once the clear is over.
- R9: A read accepted in the cycle right after a write to the same address returns the newly written data.
- R10: After reset, rsp_valid is low and req_ready is high.
- R11: An all-zero enable vector makes a read. The data word of a read has no effect on the memory.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| clear | input | 1 | Drop all pending responses |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted on this edge if valid |
| req_lane_en | input | LANES | Per-lane write enable; zero means read |
| req_want_ack | input | 1 | Write asks for an acknowledgement |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | DATA_W | Write data |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Consumer takes the response |
| rsp_data | output | DATA_W | Read word, or zero for an acknowledgement |

## Verification
The risky overlap is a clear that falls in the same cycle as a new acceptance and as a result leaving the read pipeline. The bench provokes it by issuing two back-to-back reads with clear raised during the second one. It then judges that no response ever appears and that req_ready comes back high. A second overlap also gets a directed test: on the two-stage instance with bypass, an acknowledged write follows a read. The bench checks that the write is held off for one cycle and that both responses come out in request order.

// File: rtl/bram_srv_pkg.sv
// Package: helpers shared by the block RAM server modules.
// Assumes: callers pass non-negative sizes.
package bram_srv_pkg;

    // Number of words held by the array: zero selects the full address space.
    function automatic int array_words(input int addr_w, input int mem_words);
        return (mem_words == 0) ? (1 << addr_w) : mem_words;
    endfunction

    // Bits needed to hold a count from 0 to max_val inclusive.
    function automatic int count_width(input int max_val);
        return (max_val < 2) ? 1 : $clog2(max_val + 1);
    endfunction

endpackage

// File: rtl/bram_lane_mem.sv
// Module: lane-split synchronous memory with a registered read port.
// What it does: stores WORDS words split into LANES lanes. A lane is written
// when its enable bit is set. A read registers the addressed word on the edge
// that accepts it.
// Assumes: reads and writes never fall in the same cycle (single port);
// contents are not initialised; out-of-range addresses write nothing and read zero.
module bram_lane_mem #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32,
    parameter int LANES  = 4,
    parameter int WORDS  = 256
) (
    input  logic              clk,
    input  logic              rd_en,
    input  logic [LANES-1:0]  wr_lane,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);
    localparam int LANE_W = DATA_W / LANES;

    logic addr_ok;

    // Range check of the word address against the array size.
    always_comb addr_ok = (int'({1'b0, addr}) < WORDS);

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [LANE_W-1:0] cells [WORDS];
        logic [LANE_W-1:0] rd_q;

        // Lane write: only this lane's slice of the data word is stored.
        always_ff @(posedge clk) begin
            if (wr_lane[g] && addr_ok) begin
                cells[addr] <= wdata[g*LANE_W +: LANE_W];
            end
        end

        // Lane read: capture the addressed slice into the read register.
        always_ff @(posedge clk) begin
            if (rd_en) begin
                rd_q <= addr_ok ? cells[addr] : '0;
            end
        end

        assign rdata[g*LANE_W +: LANE_W] = rd_q;
    end

endmodule

// File: rtl/bram_rd_pipe.sv
// Module: valid/tag pipeline that follows the memory read latency.
// What it does: carries one valid bit and an acknowledge tag per stage. With
// LATENCY 1 the result is the memory read register. With LATENCY 2 it adds a
// data register. Acknowledge results are forced to zero.
// Assumes: mem_rdata is the word captured on the edge that accepted in_valid;
// LATENCY values above 2 behave as 2.
module bram_rd_pipe #(
    parameter int DATA_W  = 32,
    parameter int LATENCY = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic              in_valid,
    input  logic              in_ack,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_data,
    output logic              first_busy
);
    logic s1_valid;
    logic s1_ack;

    // Stage one: mark the accepted operation and remember if it is an acknowledgement.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            s1_valid <= 1'b0;
            s1_ack   <= 1'b0;
        end else begin
            s1_valid <= in_valid;
            s1_ack   <= in_ack;
        end
    end

    assign first_busy = s1_valid;

    if (LATENCY <= 1) begin : g_lat1
        // Result leaves straight from the memory read register.
        always_comb begin
            out_valid = s1_valid;
            out_data  = s1_ack ? '0 : mem_rdata;
        end
    end else begin : g_lat2
        logic              s2_valid;
        logic [DATA_W-1:0] s2_data;

        // Stage two: register the read word, adding one cycle of latency.
        always_ff @(posedge clk) begin
            if (!rst_n || flush) begin
                s2_valid <= 1'b0;
                s2_data  <= '0;
            end else begin
                s2_valid <= s1_valid;
                s2_data  <= s1_ack ? '0 : mem_rdata;
            end
        end

        always_comb begin
            out_valid = s2_valid;
            out_data  = s2_data;
        end
    end

endmodule

// File: rtl/bram_out_fifo.sv
// Module: output FIFO with two ordered write ports and one read port.
// What it does: port a (older, pipeline result) and port b (younger,
// bypassed acknowledgement) can both write in one cycle and keep that order.
// The head is shown first-word-fall-through.
// Assumes: the caller never pushes past DEPTH (reservation is upstream).
module bram_out_fifo #(
    parameter int DATA_W = 32,
    parameter int DEPTH  = 3,
    parameter int CW     = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic              push_a,
    input  logic [DATA_W-1:0] data_a,
    input  logic              push_b,
    input  logic [DATA_W-1:0] data_b,
    input  logic              pop,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_data,
    output logic [CW-1:0]     count
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [DATA_W-1:0] slots [DEPTH];
    logic [PW-1:0]     wptr;
    logic [PW-1:0]     rptr;
    logic [PW-1:0]     wptr_b;
    logic [PW-1:0]     wptr_nxt;

    function automatic logic [PW-1:0] step(input logic [PW-1:0] p);
        return (int'(p) == DEPTH - 1) ? '0 : p + 1'b1;
    endfunction

    // Slot selection for the younger port and the next write pointer.
    always_comb begin
        wptr_b = push_a ? step(wptr) : wptr;
        if (push_a && push_b) begin
            wptr_nxt = step(step(wptr));
        end else if (push_a || push_b) begin
            wptr_nxt = step(wptr);
        end else begin
            wptr_nxt = wptr;
        end
    end

    // Storage writes; slot contents need no reset.
    always_ff @(posedge clk) begin
        if (push_a) begin
            slots[wptr] <= data_a;
        end
        if (push_b) begin
            slots[wptr_b] <= data_b;
        end
    end

    // Pointer and occupancy tracking; reset and flush empty the FIFO.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            wptr  <= '0;
            rptr  <= '0;
            count <= '0;
        end else begin
            wptr  <= wptr_nxt;
            if (pop) begin
                rptr <= step(rptr);
            end
            count <= count + CW'(push_a) + CW'(push_b) - CW'(pop);
        end
    end

    always_comb begin
        out_valid = (count != '0);
        out_data  = slots[rptr];
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        !flush |-> (int'(count) + int'(push_a) + int'(push_b) - int'(pop)) <= DEPTH); // R3

endmodule

// File: rtl/bram_credit.sv
// Module: reservation tracker for the output FIFO.
// What it does: counts results still inside the read pipeline. It allows a new
// response-producing request only while that count plus the FIFO occupancy
// is below the FIFO depth.
// Assumes: take is already gated by clear; give is the pipeline exit valid.
module bram_credit
    import bram_srv_pkg::*;
#(
    parameter int DEPTH   = 3,
    parameter int LATENCY = 1,
    parameter int CW      = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flush,
    input  logic          take,
    input  logic          give,
    input  logic [CW-1:0] fifo_count,
    output logic          room
);
    localparam int IW = count_width(LATENCY + 1);

    logic [IW-1:0] inflight;

    // In-flight count: up on pipeline entry, down on pipeline exit, zero on flush.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            inflight <= '0;
        end else begin
            inflight <= inflight + IW'(take) - IW'(give);
        end
    end

    // Room check against the FIFO depth.
    always_comb room = (int'(inflight) + int'(fifo_count)) < DEPTH;

    AST_INFLIGHT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        int'(inflight) <= LATENCY); // R3

    AST_EXIT_HAS_CREDIT: assert property (@(posedge clk) disable iff (!rst_n)
        give |-> inflight != '0); // R3

endmodule

// File: rtl/bram_server.sv
// Module: block RAM request/response server (top).
// What it does: accepts read and lane-enabled write requests on a valid/ready
// channel. It returns read words and optional zero acknowledgements, in order,
// on a valid/ready response channel through an output FIFO that cannot overflow.
// Assumes: single clock; requesters must not make req_valid depend on req_ready;
// LATENCY is 1 or 2; DATA_W is a multiple of LANES.
module bram_server
    import bram_srv_pkg::*;
#(
    parameter int ADDR_W    = 8,
    parameter int DATA_W    = 32,
    parameter int LANES     = 4,
    parameter int MEM_WORDS = 0,
    parameter int LATENCY   = 1,
    parameter int OUT_DEPTH = LATENCY + 2,
    parameter bit WR_BYPASS = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [LANES-1:0]  req_lane_en,
    input  logic              req_want_ack,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rsp_valid,
    input  logic              rsp_ready,
    output logic [DATA_W-1:0] rsp_data
);
    localparam int WORDS = array_words(ADDR_W, MEM_WORDS);
    localparam int CW    = count_width(OUT_DEPTH);

    logic              is_write;
    logic              wants_rsp;
    logic              goes_bypass;
    logic              order_hazard;
    logic              has_room;
    logic              accept;
    logic              pipe_take;
    logic              bypass_push;
    logic              mem_rd_en;
    logic [LANES-1:0]  mem_wr_lane;
    logic [DATA_W-1:0] mem_rdata;
    logic              pipe_out_valid;
    logic [DATA_W-1:0] pipe_out_data;
    logic              pipe_first_busy;
    logic              fifo_push_a;
    logic              rsp_pop;
    logic [CW-1:0]     fifo_count;

    // Request decode and acceptance: classify the operation, apply reservation and ordering.
    always_comb begin
        is_write     = |req_lane_en;
        wants_rsp    = !is_write || req_want_ack;
        goes_bypass  = WR_BYPASS && is_write && req_want_ack;
        order_hazard = (LATENCY > 1) && goes_bypass && pipe_first_busy;
        req_ready    = has_room && !order_hazard;
        accept       = req_valid && req_ready;
        pipe_take    = accept && wants_rsp && !goes_bypass && !clear;
        bypass_push  = accept && goes_bypass && !clear;
        mem_rd_en    = accept && !is_write;
        mem_wr_lane  = accept ? req_lane_en : '0;
        fifo_push_a  = pipe_out_valid && !clear;
        rsp_pop      = rsp_valid && rsp_ready;
    end

    bram_lane_mem #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .LANES  (LANES),
        .WORDS  (WORDS)
    ) u_mem (
        .clk     (clk),
        .rd_en   (mem_rd_en),
        .wr_lane (mem_wr_lane),
        .addr    (req_addr),
        .wdata   (req_wdata),
        .rdata   (mem_rdata)
    );

    bram_rd_pipe #(
        .DATA_W  (DATA_W),
        .LATENCY (LATENCY)
    ) u_pipe (
        .clk        (clk),
        .rst_n      (rst_n),
        .flush      (clear),
        .in_valid   (pipe_take),
        .in_ack     (is_write),
        .mem_rdata  (mem_rdata),
        .out_valid  (pipe_out_valid),
        .out_data   (pipe_out_data),
        .first_busy (pipe_first_busy)
    );

    bram_credit #(
        .DEPTH   (OUT_DEPTH),
        .LATENCY (LATENCY),
        .CW      (CW)
    ) u_credit (
        .clk        (clk),
        .rst_n      (rst_n),
        .flush      (clear),
        .take       (pipe_take),
        .give       (pipe_out_valid),
        .fifo_count (fifo_count),
        .room       (has_room)
    );

    bram_out_fifo #(
        .DATA_W (DATA_W),
        .DEPTH  (OUT_DEPTH),
        .CW     (CW)
    ) u_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush     (clear),
        .push_a    (fifo_push_a),
        .data_a    (pipe_out_data),
        .push_b    (bypass_push),
        .data_b    ('0),
        .pop       (rsp_pop),
        .out_valid (rsp_valid),
        .out_data  (rsp_data),
        .count     (fifo_count)
    );

    AST_HOLD_WHILE_STALLED: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_ready && !clear) |=> (rsp_valid && $stable(rsp_data))); // R1

    AST_CLEAR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> !rsp_valid); // R7

    AST_BYPASS_SAME_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && goes_bypass && !clear) |=> rsp_valid); // R6

    AST_FULL_BLOCKS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(fifo_count) == OUT_DEPTH) |-> !req_ready); // R3

endmodule

// File: tb/bram_server_tb.sv
`timescale 1ns/1ps
module bram_server_tb;
    localparam int AW = 4;
    localparam int DW = 32;
    localparam int NL = 4;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic          rst_n, clear;
    logic          req_valid, req_ready, req_want_ack;
    logic [NL-1:0] req_lane_en;
    logic [AW-1:0] req_addr;
    logic [DW-1:0] req_wdata;
    logic          rsp_valid, rsp_ready;
    logic [DW-1:0] rsp_data;

    logic          req_valid_b, req_ready_b, req_want_ack_b;
    logic [NL-1:0] req_lane_en_b;
    logic [AW-1:0] req_addr_b;
    logic [DW-1:0] req_wdata_b;
    logic          rsp_valid_b, rsp_ready_b;
    logic [DW-1:0] rsp_data_b;

    bram_server #(.ADDR_W(AW), .DATA_W(DW), .LANES(NL)) u_dut (
        .clk(clk), .rst_n(rst_n), .clear(clear),
        .req_valid(req_valid), .req_ready(req_ready), .req_lane_en(req_lane_en),
        .req_want_ack(req_want_ack), .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data)
    );

    bram_server #(.ADDR_W(AW), .DATA_W(DW), .LANES(NL), .LATENCY(2), .WR_BYPASS(1'b1)) u_dut_b (
        .clk(clk), .rst_n(rst_n), .clear(1'b0),
        .req_valid(req_valid_b), .req_ready(req_ready_b), .req_lane_en(req_lane_en_b),
        .req_want_ack(req_want_ack_b), .req_addr(req_addr_b), .req_wdata(req_wdata_b),
        .rsp_valid(rsp_valid_b), .rsp_ready(rsp_ready_b), .rsp_data(rsp_data_b)
    );

    int n_run  = 0;
    int n_fail = 0;

    task automatic chk(input bit ok, input int rq, input logic [DW-1:0] act,
                       input logic [DW-1:0] exp, input string what);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL R%0d %s: actual %h expected %h", rq, what, act, exp);
        end
    endtask

    // Stimulus table: lane enables, ack flag, address, data, response expected, expected word, requirement.
    typedef struct packed {
        logic [3:0]  wen;
        logic        ack;
        logic [3:0]  addr;
        logic [31:0] wdata;
        logic        rsp;
        logic [31:0] exp;
        logic [3:0]  rq;
    } vec_t;

    localparam vec_t VECS [10] = '{
        '{4'hF, 1'b0, 4'd1, 32'hA1B2C3D4, 1'b0, 32'h0,        4'd5},  // R5 silent write
        '{4'h0, 1'b0, 4'd1, 32'h0,        1'b1, 32'hA1B2C3D4, 4'd9},  // R9 read after write
        '{4'h3, 1'b1, 4'd1, 32'h11112222, 1'b1, 32'h0,        4'd5},  // R5 zero ack
        '{4'h0, 1'b0, 4'd1, 32'h0,        1'b1, 32'hA1B22222, 4'd2},  // R2 low lanes only
        '{4'hF, 1'b1, 4'd2, 32'h0F0F0F0F, 1'b1, 32'h0,        4'd5},  // R5
        '{4'h0, 1'b0, 4'd2, 32'h0,        1'b1, 32'h0F0F0F0F, 4'd1},  // R1
        '{4'h0, 1'b0, 4'd1, 32'hFFFFFFFF, 1'b1, 32'hA1B22222, 4'd11}, // R11 data ignored
        '{4'h8, 1'b0, 4'd2, 32'hEE000000, 1'b0, 32'h0,        4'd2},  // R2 top lane
        '{4'h0, 1'b0, 4'd2, 32'h0,        1'b1, 32'hEE0F0F0F, 4'd2},  // R2 R9
        '{4'h0, 1'b0, 4'd1, 32'h0,        1'b1, 32'hA1B22222, 4'd11}  // R11 memory kept
    };

    logic [35:0] exp_q [$];

    // Consumer ready: held off, pulsed, or always on; changes just after a rising edge.
    logic hold  = 1'b1;
    logic stall = 1'b0;
    int   cyc   = 0;
    initial rsp_ready = 1'b0;
    always @(posedge clk) begin
        #1;
        cyc = cyc + 1;
        rsp_ready <= hold ? 1'b0 : (stall ? (cyc % 3 != 0) : 1'b1);
    end

    // Response monitor: every handshake is compared with the expected queue head.
    always @(negedge clk) begin
        if (rst_n && rsp_valid && rsp_ready) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, 1, rsp_data, '0, "unexpected response");
            end else begin
                logic [35:0] e;
                e = exp_q.pop_front();
                chk(rsp_data == e[31:0], int'(e[35:32]), rsp_data, e[31:0], "response word");
            end
        end
    end

    task automatic send(input logic [3:0] wen, input logic ack, input logic [3:0] addr,
                        input logic [31:0] data);
        req_valid    = 1'b1;
        req_lane_en  = wen;
        req_want_ack = ack;
        req_addr     = addr;
        req_wdata    = data;
        #1;
        while (!req_ready) begin
            @(negedge clk);
            #1;
        end
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic drain();
        for (int i = 0; i < 100 && exp_q.size() != 0; i++) @(negedge clk);
        chk(exp_q.size() == 0, 1, DW'(exp_q.size()), '0, "all responses delivered");
    endtask

    initial begin
        rst_n = 1'b0; clear = 1'b0;
        req_valid = 1'b0; req_lane_en = '0; req_want_ack = 1'b0; req_addr = '0; req_wdata = '0;
        req_valid_b = 1'b0; req_lane_en_b = '0; req_want_ack_b = 1'b0; req_addr_b = '0;
        req_wdata_b = '0; rsp_ready_b = 1'b0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!rsp_valid, 10, DW'(rsp_valid), '0, "no response after reset");    // R10
        chk(req_ready, 10, DW'(req_ready), 32'h1, "ready after reset");        // R10

        // Table walk with a pulsing consumer.
        hold = 1'b0; stall = 1'b1;
        for (int i = 0; i < 10; i++) begin
            if (VECS[i].rsp) exp_q.push_back({VECS[i].rq, VECS[i].exp});
            send(VECS[i].wen, VECS[i].ack, VECS[i].addr, VECS[i].wdata);
        end
        drain();
        stall = 1'b0;

        // R4 read latency 1 and R5 pipelined ack timing, consumer held off.
        hold = 1'b1;
        repeat (2) @(negedge clk);
        exp_q.push_back({4'd4, 32'hA1B22222});
        send(4'h0, 1'b0, 4'd1, '0);
        chk(!rsp_valid, 4, DW'(rsp_valid), '0, "read not visible at t");
        @(negedge clk);
        chk(rsp_valid, 4, DW'(rsp_valid), 32'h1, "read visible at t+1");
        hold = 1'b0;
        drain();
        hold = 1'b1;
        repeat (2) @(negedge clk);
        exp_q.push_back({4'd5, 32'h0});
        send(4'hF, 1'b1, 4'd5, 32'h77777777);
        chk(!rsp_valid, 5, DW'(rsp_valid), '0, "ack not visible at t");
        @(negedge clk);
        chk(rsp_valid, 5, DW'(rsp_valid), 32'h1, "ack visible at t+1");
        hold = 1'b0;
        drain();

        // R3 reservation: consumer stalled, keep offering reads.
        hold = 1'b1;
        repeat (2) @(negedge clk);
        begin
            int acc;
            acc = 0;
            req_lane_en = '0; req_want_ack = 1'b0; req_addr = 4'd2; req_valid = 1'b1;
            for (int i = 0; i < 10; i++) begin
                #1;
                if (req_ready) begin
                    acc++;
                    exp_q.push_back({4'd3, 32'hEE0F0F0F});
                end
                @(negedge clk);
            end
            chk(acc == 3, 3, DW'(acc), 32'd3, "accepted while stalled");
            chk(!req_ready, 3, DW'(req_ready), '0, "ready low when full");
            req_valid = 1'b0;
        end
        hold = 1'b0;
        drain();

        // R7 clear empties pending responses.
        hold = 1'b1;
        repeat (2) @(negedge clk);
        send(4'h0, 1'b0, 4'd1, '0);
        send(4'h0, 1'b0, 4'd2, '0);
        @(negedge clk);
        chk(rsp_valid, 7, DW'(rsp_valid), 32'h1, "responses pending before clear");
        clear = 1'b1;
        @(negedge clk);
        clear = 1'b0;
        chk(!rsp_valid, 7, DW'(rsp_valid), '0, "empty after clear");

        // R8 clear together with an acceptance and a pipeline exit.
        req_lane_en = '0; req_want_ack = 1'b0; req_addr = 4'd1; req_valid = 1'b1;
        @(negedge clk);
        clear = 1'b1;
        req_addr = 4'd2;
        @(negedge clk);
        clear = 1'b0;
        req_valid = 1'b0;
        repeat (3) @(negedge clk);
        chk(!rsp_valid, 8, DW'(rsp_valid), '0, "no response from cleared work");
        chk(req_ready, 8, DW'(req_ready), 32'h1, "ready after clear");

        // R7 memory kept through clear.
        hold = 1'b0;
        repeat (2) @(negedge clk);
        exp_q.push_back({4'd7, 32'hA1B22222});
        exp_q.push_back({4'd7, 32'hEE0F0F0F});
        send(4'h0, 1'b0, 4'd1, '0);
        send(4'h0, 1'b0, 4'd2, '0);
        drain();

        // Second instance: LATENCY 2 with write bypass.
        req_valid_b = 1'b1; req_lane_en_b = 4'hF; req_want_ack_b = 1'b1;
        req_addr_b = 4'd3; req_wdata_b = 32'h12345678;
        #1;
        chk(req_ready_b, 6, DW'(req_ready_b), 32'h1, "bypass write offered");
        @(negedge clk);
        req_valid_b = 1'b0;
        chk(rsp_valid_b && rsp_data_b == 32'h0, 6, rsp_data_b, 32'h0, "ack same cycle");
        rsp_ready_b = 1'b1;
        @(negedge clk);
        rsp_ready_b = 1'b0;
        chk(!rsp_valid_b, 6, DW'(rsp_valid_b), '0, "ack taken");
        req_valid_b = 1'b1; req_lane_en_b = '0; req_want_ack_b = 1'b0;
        @(negedge clk);
        req_valid_b = 1'b0;
        chk(!rsp_valid_b, 4, DW'(rsp_valid_b), '0, "latency2 not at t");
        @(negedge clk);
        chk(!rsp_valid_b, 4, DW'(rsp_valid_b), '0, "latency2 not at t+1");
        @(negedge clk);
        chk(rsp_valid_b && rsp_data_b == 32'h12345678, 4, rsp_data_b, 32'h12345678,
            "latency2 read at t+2");
        rsp_ready_b = 1'b1;
        @(negedge clk);
        rsp_ready_b = 1'b0;

        // R6 ordering: bypass write right after a read waits one cycle.
        req_valid_b = 1'b1; req_lane_en_b = '0; req_want_ack_b = 1'b0; req_addr_b = 4'd3;
        @(negedge clk);
        req_lane_en_b = 4'hF; req_want_ack_b = 1'b1; req_addr_b = 4'd4; req_wdata_b = 32'h5;
        #1;
        chk(!req_ready_b, 6, DW'(req_ready_b), '0, "bypass held behind read");
        @(negedge clk);
        #1;
        chk(req_ready_b, 6, DW'(req_ready_b), 32'h1, "bypass released");
        @(negedge clk);
        req_valid_b = 1'b0;
        chk(rsp_valid_b && rsp_data_b == 32'h12345678, 1, rsp_data_b, 32'h12345678,
            "older read first");
        rsp_ready_b = 1'b1;
        @(negedge clk);
        rsp_ready_b = 1'b0;
        chk(rsp_valid_b && rsp_data_b == 32'h0, 1, rsp_data_b, 32'h0, "younger ack second");
        rsp_ready_b = 1'b1;
        @(negedge clk);
        rsp_ready_b = 1'b0;

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        #200000;
        n_run++;
        n_fail++;
        $display("FAIL R1 watchdog expired: actual %0d expected %0d", 1, 0);
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule